// File: doc/BRIEF.md
# Two-Phase Display Link Training Sequencer

This block brings up a multi-lane serial display link. After a start pulse it writes the setup registers of the attached sink and asks the local transmitter to begin training. It then runs two loops in a fixed order. The clock-recovery loop comes first and the channel-equalization loop second. In each loop it waits a set number of microsecond ticks and reads the sink's six-byte status block. If the status is not yet good, it turns the sink's requested swing and pre-emphasis into a new drive byte and writes that byte to every active lane. At the end it turns the training pattern off, tells the transmitter that training is complete, and reports one result for each phase.

The sink is reached through a one-byte register request port with an address, a write flag, a write byte, and an acknowledge. A read returns the whole status block on a 48-bit bus in the cycle it is acknowledged. Transmitter actions use a separate request/acknowledge pair. The tick input sets all waiting, so absolute time is defined outside the block. The settings the block works on are taken at start: lane count (1, 2 or 4), link rate select, and sink revision.

Top module: `link_train_seq`

## Requirements
- R1: Setup runs in this order, one request completing before the next begins. First, if revision >= 0x11, write 0x01 to 0x600. Then write 0x00 to 0x102. Then write the rate byte to 0x100: 0x0A when rate_high is set, else 0x06. Then write to 0x101 the lane count, with bit 7 set when revision >= 0x11. Then write 0x00 to 0x107. Then issue transmitter action 0 (start), and then action 1 with pattern select 0.
- R2: After setup the block waits SETUP_WAIT ticks and writes 0x01 to 0x102. It then writes the drive byte, 0x00 at this point, to address 0x103+i for each active lane i, in increasing lane order.
- R3: Each clock-recovery pass waits CR_WAIT ticks, then reads status at 0x202. Lane i's status nibble is at bits 4i+3:4i of the status bus. The phase passes when bit 0 of that nibble is set on every active lane. Inactive lanes are ignored.
- R4: Clock recovery ends in failure when the current drive byte has its max-swing flag (bit 2) set and the status does not pass.
- R5: Clock recovery ends in failure on the pass in which the lane-0 swing has matched the previous pass's swing for the fifth time in a row. Any change of swing restarts the count. With a sink that never passes and always requests swing 0, this happens on the sixth status read.
- R6: The new drive byte holds the largest swing (bits 1:0) and the largest pre-emphasis (bits 4:3) requested by any active lane. Requests sit at status bits 32+4i+1:32+4i for swing and 32+4i+3:32+4i+2 for pre-emphasis. Swing 3 sets flag bit 2. Pre-emphasis is limited to 2, 2, 1, 0 for swing 0 to 3, and reaching the limit sets flag bit 5. The byte is also driven on drive_level.
- R7: Equalization starts by writing 0x02 to 0x102 and then issuing action 1 with pattern select 1. Each pass waits EQ_WAIT ticks before the status read.
- R8: Equalization passes only when status bit 16 (lanes aligned) is set and bits 2:0 of every active lane's nibble are all set.
- R9: Equalization fails on the seventh status read that does not pass. Drive updates are written after each of the first six.
- R10: A read answered with rsp_ok low ends its loop in failure. The equalization phase still runs after clock recovery fails.
- R11: The sequence ends with a write of 0x00 to 0x102 and then action 2 (complete). A one-cycle done follows, with cr_ok and eq_ok valid in that cycle. busy is high from the cycle after start until done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | One-cycle timing tick |
| start | input | 1 | Begin a training run when idle |
| lane_count | input | 3 | Active lanes: 1, 2, otherwise 4 |
| rate_high | input | 1 | Selects the higher link rate |
| sink_rev | input | 8 | Sink revision byte |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| cr_ok | output | 1 | Clock recovery passed, valid with done |
| eq_ok | output | 1 | Equalization passed, valid with done |
| req_valid | output | 1 | Sink register request pending |
| req_write | output | 1 | 1 for write, 0 for status read |
| req_addr | output | ADDR_W | Sink register address |
| req_wdata | output | 8 | Write byte |
| req_ack | input | 1 | Request completed |
| rsp_ok | input | 1 | Read succeeded, valid with req_ack |
| rsp_data | input | 48 | Status block, byte k at bits 8k+7:8k |
| src_valid | output | 1 | Transmitter action pending |
| src_action | output | 2 | 0 start, 1 pattern select, 2 complete |
| src_pattern | output | 1 | Pattern select: 0 first, 1 second |
| src_ack | input | 1 | Transmitter action completed |
| drive_level | output | 8 | Current per-lane drive byte |

## Verification
First, every lane count is swept with both revisions and both rates against a sink that passes at once. This separates the conditional power write, the lane byte, and the number of drive writes. Next, the clock-recovery sink changes its swing requests: held at zero (repeat abort), stepping upward (max-swing abort), mixed across lanes (largest-value merge), and high pre-emphasis at swing 2 (cap and flag). Lane count 1 shows that lanes outside the active set are ignored for both pass decisions and adjustments. Equalization sinks that lack only alignment or only the lane bits, together with failed reads in each loop, separate the try limit from the read-error path.

// File: rtl/link_train_seq.sv
module link_train_seq #(
  parameter int ADDR_W        = 12,
  parameter int SETUP_WAIT    = 400,
  parameter int CR_WAIT       = 100,
  parameter int EQ_WAIT       = 400,
  parameter int CR_SAME_LIMIT = 5,
  parameter int EQ_TRY_LIMIT  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_us,
  input  logic              start,
  input  logic [2:0]        lane_count,
  input  logic              rate_high,
  input  logic [7:0]        sink_rev,
  output logic              busy,
  output logic              done,
  output logic              cr_ok,
  output logic              eq_ok,
  output logic              req_valid,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [7:0]        req_wdata,
  input  logic              req_ack,
  input  logic              rsp_ok,
  input  logic [47:0]       rsp_data,
  output logic              src_valid,
  output logic [1:0]        src_action,
  output logic              src_pattern,
  input  logic              src_ack,
  output logic [7:0]        drive_level
);
  localparam int WAIT_A   = SETUP_WAIT > CR_WAIT ? SETUP_WAIT : CR_WAIT;
  localparam int WAIT_MAX = WAIT_A > EQ_WAIT ? WAIT_A : EQ_WAIT;
  localparam int TMR_W    = $clog2(WAIT_MAX + 1);
  localparam int TRY_MAX  = CR_SAME_LIMIT > EQ_TRY_LIMIT + 1 ? CR_SAME_LIMIT : EQ_TRY_LIMIT + 1;
  localparam int TRY_W    = $clog2(TRY_MAX + 1);

  localparam logic [ADDR_W-1:0] A_RATE   = ADDR_W'(12'h100);
  localparam logic [ADDR_W-1:0] A_LANES  = ADDR_W'(12'h101);
  localparam logic [ADDR_W-1:0] A_PAT    = ADDR_W'(12'h102);
  localparam logic [ADDR_W-1:0] A_DRIVE  = ADDR_W'(12'h103);
  localparam logic [ADDR_W-1:0] A_SPREAD = ADDR_W'(12'h107);
  localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(12'h202);
  localparam logic [ADDR_W-1:0] A_PWR    = ADDR_W'(12'h600);

  typedef enum logic [4:0] {
    S_IDLE, S_PWR, S_POFF, S_RATE, S_LANES, S_SPREAD, S_SRC_GO, S_SRC_P1,
    S_INIT_WAIT, S_PAT1, S_DRIVE, S_CR_WAIT, S_CR_READ, S_CR_EVAL,
    S_PAT2, S_SRC_P2, S_EQ_WAIT, S_EQ_READ, S_EQ_EVAL, S_PEND, S_SRC_END, S_FIN
  } state_t;

  state_t             state;
  logic [TMR_W-1:0]   tmr;
  logic [TRY_W-1:0]   tries;
  logic [1:0]         lane_idx;
  logic [7:0]         drv;
  logic [1:0]         last_v;
  logic               have_v;
  logic               cr_pass, eq_pass, st_ok, in_eq;
  logic [47:0]        st_q;
  logic [2:0]         lanes_q;
  logic               rate_q, enh_q;

  logic [3:0]         mask;
  logic [1:0]         last_lane;
  logic               cr_all, eq_all;
  logic [1:0]         vmax, pmax, pcap, p_new;
  logic               p_flag;
  logic [7:0]         drv_next;
  logic               waiting, wait_done;
  logic [TMR_W-1:0]   wait_lim;

  assign mask      = lanes_q == 3'd1 ? 4'b0001 : lanes_q == 3'd2 ? 4'b0011 : 4'b1111;
  assign last_lane = lanes_q == 3'd1 ? 2'd0 : lanes_q == 3'd2 ? 2'd1 : 2'd3;

  always_comb begin
    cr_all = 1'b1;
    eq_all = st_q[16];
    vmax   = 2'd0;
    pmax   = 2'd0;
    for (int i = 0; i < 4; i++) begin
      if (mask[i]) begin
        if (!st_q[4*i]) cr_all = 1'b0;
        if (st_q[4*i +: 3] != 3'b111) eq_all = 1'b0;
        if (st_q[32+4*i +: 2] > vmax) vmax = st_q[32+4*i +: 2];
        if (st_q[34+4*i +: 2] > pmax) pmax = st_q[34+4*i +: 2];
      end
    end
  end

  assign pcap     = vmax == 2'd3 ? 2'd0 : vmax == 2'd2 ? 2'd1 : 2'd2;
  assign p_flag   = pmax >= pcap;
  assign p_new    = p_flag ? pcap : pmax;
  assign drv_next = {2'b00, p_flag, p_new, vmax == 2'd3, vmax};

  assign waiting   = state == S_INIT_WAIT || state == S_CR_WAIT || state == S_EQ_WAIT;
  assign wait_lim  = state == S_CR_WAIT ? TMR_W'(CR_WAIT - 1) :
                     state == S_EQ_WAIT ? TMR_W'(EQ_WAIT - 1) : TMR_W'(SETUP_WAIT - 1);
  assign wait_done = waiting && tick_us && tmr == wait_lim;

  always_ff @(posedge clk) begin
    if (!rst_n) tmr <= '0;
    else if (!waiting || wait_done) tmr <= '0;
    else if (tick_us) tmr <= tmr + 1'b1;
  end

  always_comb begin
    req_valid = 1'b1;
    req_write = 1'b1;
    req_addr  = A_PAT;
    req_wdata = 8'h00;
    case (state)
      S_PWR:    begin req_addr = A_PWR;  req_wdata = 8'h01; end
      S_POFF:   ;
      S_RATE:   begin req_addr = A_RATE; req_wdata = rate_q ? 8'h0A : 8'h06; end
      S_LANES:  begin req_addr = A_LANES; req_wdata = {enh_q, 4'b0000, lanes_q}; end
      S_SPREAD: req_addr = A_SPREAD;
      S_PAT1:   req_wdata = 8'h01;
      S_DRIVE:  begin req_addr = A_DRIVE + ADDR_W'(lane_idx); req_wdata = drv; end
      S_CR_READ, S_EQ_READ: begin req_write = 1'b0; req_addr = A_STAT; end
      S_PAT2:   req_wdata = 8'h02;
      S_PEND:   ;
      default:  req_valid = 1'b0;
    endcase
  end

  assign src_valid   = state == S_SRC_GO || state == S_SRC_P1 || state == S_SRC_P2 || state == S_SRC_END;
  assign src_action  = state == S_SRC_GO ? 2'd0 : state == S_SRC_END ? 2'd2 : 2'd1;
  assign src_pattern = state == S_SRC_P2;

  assign busy        = state != S_IDLE;
  assign done        = state == S_FIN;
  assign cr_ok       = done && cr_pass;
  assign eq_ok       = done && eq_pass;
  assign drive_level = drv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      tries    <= '0;
      lane_idx <= 2'd0;
      drv      <= 8'h00;
      last_v   <= 2'd0;
      have_v   <= 1'b0;
      cr_pass  <= 1'b0;
      eq_pass  <= 1'b0;
      st_ok    <= 1'b0;
      in_eq    <= 1'b0;
      st_q     <= '0;
      lanes_q  <= 3'd1;
      rate_q   <= 1'b0;
      enh_q    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          lanes_q <= lane_count == 3'd1 ? 3'd1 : lane_count == 3'd2 ? 3'd2 : 3'd4;
          rate_q  <= rate_high;
          enh_q   <= sink_rev >= 8'h11;
          drv     <= 8'h00;
          have_v  <= 1'b0;
          tries   <= '0;
          cr_pass <= 1'b0;
          eq_pass <= 1'b0;
          in_eq   <= 1'b0;
          state   <= sink_rev >= 8'h11 ? S_PWR : S_POFF;
        end
        S_PWR:       if (req_ack) state <= S_POFF;
        S_POFF:      if (req_ack) state <= S_RATE;
        S_RATE:      if (req_ack) state <= S_LANES;
        S_LANES:     if (req_ack) state <= S_SPREAD;
        S_SPREAD:    if (req_ack) state <= S_SRC_GO;
        S_SRC_GO:    if (src_ack) state <= S_SRC_P1;
        S_SRC_P1:    if (src_ack) state <= S_INIT_WAIT;
        S_INIT_WAIT: if (wait_done) state <= S_PAT1;
        S_PAT1: if (req_ack) begin
          lane_idx <= 2'd0;
          state    <= S_DRIVE;
        end
        S_DRIVE: if (req_ack) begin
          if (lane_idx == last_lane) state <= in_eq ? S_EQ_WAIT : S_CR_WAIT;
          else lane_idx <= lane_idx + 2'd1;
        end
        S_CR_WAIT: if (wait_done) state <= S_CR_READ;
        S_CR_READ: if (req_ack) begin
          st_q  <= rsp_data;
          st_ok <= rsp_ok;
          state <= S_CR_EVAL;
        end
        S_CR_EVAL: begin
          if (!st_ok) state <= S_PAT2;
          else if (cr_all) begin
            cr_pass <= 1'b1;
            state   <= S_PAT2;
          end else if (drv[2]) state <= S_PAT2;
          else if (have_v && drv[1:0] == last_v && tries == TRY_W'(CR_SAME_LIMIT - 1)) state <= S_PAT2;
          else begin
            tries    <= (have_v && drv[1:0] == last_v) ? tries + 1'b1 : '0;
            last_v   <= drv[1:0];
            have_v   <= 1'b1;
            drv      <= drv_next;
            lane_idx <= 2'd0;
            state    <= S_DRIVE;
          end
        end
        S_PAT2:   if (req_ack) state <= S_SRC_P2;
        S_SRC_P2: if (src_ack) begin
          tries <= '0;
          in_eq <= 1'b1;
          state <= S_EQ_WAIT;
        end
        S_EQ_WAIT: if (wait_done) state <= S_EQ_READ;
        S_EQ_READ: if (req_ack) begin
          st_q  <= rsp_data;
          st_ok <= rsp_ok;
          state <= S_EQ_EVAL;
        end
        S_EQ_EVAL: begin
          if (!st_ok) state <= S_PEND;
          else if (eq_all) begin
            eq_pass <= 1'b1;
            state   <= S_PEND;
          end else if (tries > TRY_W'(EQ_TRY_LIMIT)) state <= S_PEND;
          else begin
            tries    <= tries + 1'b1;
            drv      <= drv_next;
            lane_idx <= 2'd0;
            state    <= S_DRIVE;
          end
        end
        S_PEND:    if (req_ack) state <= S_SRC_END;
        S_SRC_END: if (src_ack) state <= S_FIN;
        S_FIN:     state <= S_IDLE;
        default:   state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/link_train_seq_chk.sv
module link_train_seq_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              cr_ok,
  input logic              eq_ok,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [7:0]        req_wdata,
  input logic              req_ack,
  input logic              src_valid,
  input logic [1:0]        src_action,
  input logic              src_ack,
  input logic [7:0]        drive_level
);
  logic [1:0] cap_of_swing;
  assign cap_of_swing = drive_level[1:0] == 2'd3 ? 2'd0 : drive_level[1:0] == 2'd2 ? 2'd1 : 2'd2;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid && !src_valid); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_RESULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_ok || eq_ok) |-> done); // R11
  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy); // R11
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ack |=> req_valid && $stable(req_addr) && $stable(req_wdata) && $stable(req_write)); // R1
  AST_SRC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid && !src_ack |=> src_valid && $stable(src_action)); // R1
  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && src_valid)); // R1
  AST_SWING_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    drive_level[2] |-> drive_level[1:0] == 2'd3); // R6
  AST_PRE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    drive_level[5] |-> drive_level[4:3] == cap_of_swing); // R6
  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    drive_level[4:3] <= cap_of_swing); // R6
endmodule

bind link_train_seq link_train_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .cr_ok(cr_ok), .eq_ok(eq_ok), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
  .src_valid(src_valid), .src_action(src_action), .src_ack(src_ack),
  .drive_level(drive_level)
);

// File: tb/test_link_train_seq.sv
module test_link_train_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_us = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  lane_count = 3'd1;
  logic        rate_high = 1'b0;
  logic [7:0]  sink_rev = 8'h10;
  logic        busy, done, cr_ok, eq_ok;
  logic        req_valid, req_write;
  logic [11:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_ack = 1'b0;
  logic        rsp_ok = 1'b0;
  logic [47:0] rsp_data = '0;
  logic        src_valid;
  logic [1:0]  src_action;
  logic        src_pattern;
  logic        src_ack = 1'b0;
  logic [7:0]  drive_level;

  link_train_seq i_link_train_seq (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .start(start),
    .lane_count(lane_count), .rate_high(rate_high), .sink_rev(sink_rev),
    .busy(busy), .done(done), .cr_ok(cr_ok), .eq_ok(eq_ok),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ack(req_ack), .rsp_ok(rsp_ok), .rsp_data(rsp_data),
    .src_valid(src_valid), .src_action(src_action), .src_pattern(src_pattern),
    .src_ack(src_ack), .drive_level(drive_level)
  );

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  int lk[256], la[256], ld[256], lt[256];
  int n_log = 0, tick_total = 0;
  int ek[256], ea[256], ed[256];
  int n_exp = 0;
  int sink_pat = 0, cr_n = 0, eq_n = 0;
  int cfg_cr_at = 0, cfg_cr_fail_at = 0, cfg_eq_at = 0, cfg_eq_fail_at = 0;
  logic        cfg_ramp = 1'b0;
  logic [3:0]  cfg_cr_part = 4'h0;
  logic [15:0] cfg_adj = 16'h0;
  logic [15:0] cfg_eq_nib = 16'h0;
  logic        cfg_align = 1'b0;
  logic        res_cr, res_eq, timed_out;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] cr_status();
    logic [47:0] s = '0;
    logic [1:0]  v;
    for (int i = 0; i < 4; i++) s[4*i] = (cfg_cr_at != 0 && cr_n >= cfg_cr_at) ? 1'b1 : cfg_cr_part[i];
    if (cfg_ramp) begin
      v = cr_n >= 3 ? 2'd3 : 2'(cr_n);
      s[47:32] = {2'b00, v, 2'b00, v, 2'b00, v, 2'b00, v};
    end else s[47:32] = cfg_adj;
    return s;
  endfunction

  function automatic logic [47:0] eq_status();
    logic [47:0] s = '0;
    if (cfg_eq_at != 0 && eq_n >= cfg_eq_at) begin
      s[15:0] = 16'h7777;
      s[16]   = 1'b1;
    end else begin
      s[15:0] = cfg_eq_nib;
      s[16]   = cfg_align;
    end
    return s;
  endfunction

  always @(negedge clk) begin
    tick_us = ~tick_us;
    if (tick_us) tick_total++;
    if (req_ack) req_ack = 1'b0;
    else if (req_valid) begin
      req_ack = 1'b1;
      lt[n_log] = tick_total;
      if (req_write) begin
        lk[n_log] = 0; la[n_log] = req_addr; ld[n_log] = req_wdata;
        if (req_addr == 12'h102) sink_pat = req_wdata;
      end else begin
        lk[n_log] = 1; la[n_log] = req_addr; ld[n_log] = sink_pat;
        if (sink_pat == 1) begin
          cr_n++;
          rsp_ok   = (cfg_cr_fail_at != cr_n);
          rsp_data = cr_status();
        end else begin
          eq_n++;
          rsp_ok   = (cfg_eq_fail_at != eq_n);
          rsp_data = eq_status();
        end
      end
      if (n_log < 255) n_log++;
    end
    if (src_ack) src_ack = 1'b0;
    else if (src_valid) begin
      src_ack = 1'b1;
      lt[n_log] = tick_total;
      lk[n_log] = 2; la[n_log] = src_action; ld[n_log] = src_pattern;
      if (n_log < 255) n_log++;
    end
  end

  task automatic clear_cfg();
    cfg_cr_at = 1; cfg_cr_fail_at = 0; cfg_eq_at = 1; cfg_eq_fail_at = 0;
    cfg_ramp = 1'b0; cfg_cr_part = 4'h0; cfg_adj = 16'h0; cfg_eq_nib = 16'h0; cfg_align = 1'b0;
  endtask

  task automatic run(input int lanes, input bit rate, input int rev);
    int guard;
    @(negedge clk);
    n_log = 0; cr_n = 0; eq_n = 0; sink_pat = 0;
    lane_count = 3'(lanes); rate_high = rate; sink_rev = 8'(rev);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R11 busy after start", busy, 1);
    guard = 0;
    timed_out = 1'b0;
    while (!done && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    if (!done) begin
      timed_out = 1'b1;
      chk(1'b0, "watchdog run", guard, 20000);
    end
    res_cr = cr_ok; res_eq = eq_ok;
    @(negedge clk);
    chk(busy == 1'b0, "R11 idle after done", busy, 0);
  endtask

  task automatic push(input int k, input int a, input int d);
    ek[n_exp] = k; ea[n_exp] = a; ed[n_exp] = d; n_exp++;
  endtask

  function automatic int find(input int k, input int a, input int d, input int from);
    for (int i = from; i < n_log; i++) if (lk[i] == k && la[i] == a && ld[i] == d) return i;
    return -1;
  endfunction

  function automatic int last_drive_before_eq();
    int v = -1;
    for (int i = 0; i < n_log; i++) begin
      if (lk[i] == 0 && la[i] == 12'h102 && ld[i] == 2) return v;
      if (lk[i] == 0 && la[i] == 12'h103) v = ld[i];
    end
    return v;
  endfunction

  int idx, bad, d;

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && req_valid == 0 && src_valid == 0 && drive_level == 0, "R11 reset state", busy, 0);
    rst_n = 1'b1;

    // R1 R2 R3 R7 R11: full sweep with an immediately passing sink
    for (int ln = 0; ln < 3; ln++) begin
      for (int rv = 0; rv < 2; rv++) begin
        for (int rt = 0; rt < 2; rt++) begin
          int lanes = ln == 0 ? 1 : ln == 1 ? 2 : 4;
          int rev = rv ? 8'h12 : 8'h10;
          clear_cfg();
          run(lanes, rt[0], rev);
          n_exp = 0;
          if (rev >= 8'h11) push(0, 12'h600, 1);
          push(0, 12'h102, 0);
          push(0, 12'h100, rt ? 8'h0A : 8'h06);
          push(0, 12'h101, lanes | (rev >= 8'h11 ? 8'h80 : 0));
          push(0, 12'h107, 0);
          push(2, 0, 0);
          push(2, 1, 0);
          push(0, 12'h102, 1);
          for (int i = 0; i < lanes; i++) push(0, 12'h103 + i, 0);
          push(1, 12'h202, 1);
          push(0, 12'h102, 2);
          push(2, 1, 1);
          push(1, 12'h202, 2);
          push(0, 12'h102, 0);
          push(2, 2, 0);
          bad = (n_log != n_exp) ? 1 : 0;
          for (int i = 0; i < n_exp && i < n_log; i++)
            if (lk[i] != ek[i] || la[i] != ea[i] || ld[i] != ed[i]) bad++;
          chk(bad == 0, "R1 R2 R11 request order", n_log, n_exp);
          chk(res_cr && res_eq, "R3 R8 passing sink", {res_cr, res_eq}, 3);
          if (ln == 0 && rv == 0 && rt == 0) begin
            idx = find(2, 1, 0, 0);
            d = lt[idx + 1] - lt[idx];
            chk(d >= 400 && d <= 402, "R2 setup wait ticks", d, 400);
            idx = find(1, 12'h202, 1, 0);
            d = lt[idx] - lt[idx - 1];
            chk(d >= 100 && d <= 102, "R3 cr wait ticks", d, 100);
            idx = find(1, 12'h202, 2, 0);
            d = lt[idx] - lt[idx - 1];
            chk(d >= 400 && d <= 402, "R7 eq wait ticks", d, 400);
          end
        end
      end
    end

    // R5 R10: swing request never changes, CR never done; EQ still run
    clear_cfg(); cfg_cr_at = 0;
    run(2, 1'b1, 8'h12);
    chk(cr_n == 6, "R5 reads before repeat abort", cr_n, 6);
    chk(!res_cr && res_eq, "R5 R10 cr fail eq run", {res_cr, res_eq}, 1);

    // R4 R6: ramping swing reaches the maximum
    clear_cfg(); cfg_cr_at = 0; cfg_ramp = 1'b1;
    run(4, 1'b0, 8'h12);
    chk(cr_n == 4, "R4 reads before max swing abort", cr_n, 4);
    chk(last_drive_before_eq() == 8'h27, "R6 swing 3 drive byte", last_drive_before_eq(), 8'h27);
    chk(drive_level == 8'h27, "R6 drive_level port", drive_level, 8'h27);
    chk(!res_cr, "R4 cr fail", res_cr, 0);

    // R6 R3: largest request over two lanes, CR done on third read
    clear_cfg(); cfg_cr_at = 3; cfg_adj = 16'h0014;
    run(2, 1'b1, 8'h12);
    idx = find(0, 12'h103, 8'h09, 0);
    chk(idx >= 0 && lk[idx + 1] == 0 && la[idx + 1] == 12'h104 && ld[idx + 1] == 8'h09,
        "R6 merged drive on both lanes", idx, 1);
    chk(cr_n == 3 && res_cr, "R3 cr pass on third read", cr_n, 3);

    // R3: only active lane needs CR done
    clear_cfg(); cfg_cr_at = 0; cfg_cr_part = 4'b0001;
    run(1, 1'b0, 8'h12);
    chk(cr_n == 1 && res_cr, "R3 inactive lanes ignored", cr_n, 1);

    // R6: inactive lane's request ignored
    clear_cfg(); cfg_cr_at = 2; cfg_adj = 16'h0014;
    run(1, 1'b0, 8'h12);
    chk(last_drive_before_eq() == 8'h08, "R6 single lane adjust", last_drive_before_eq(), 8'h08);
    chk(find(0, 12'h104, 8'h08, 0) < 0, "R2 no write to inactive lane", find(0, 12'h104, 8'h08, 0), -1);

    // R6: pre-emphasis cap at swing 2
    clear_cfg(); cfg_cr_at = 2; cfg_adj = 16'h000E;
    run(4, 1'b0, 8'h12);
    chk(last_drive_before_eq() == 8'h2A, "R6 pre-emphasis cap", last_drive_before_eq(), 8'h2A);

    // R8 R9 R11: lanes good but alignment missing
    clear_cfg(); cfg_eq_at = 0; cfg_eq_nib = 16'h7777; cfg_align = 1'b0;
    run(2, 1'b1, 8'h12);
    chk(eq_n == 7, "R9 eq reads before give-up", eq_n, 7);
    chk(res_cr && !res_eq, "R8 align needed", {res_cr, res_eq}, 2);
    chk(n_log >= 2 && lk[n_log-2] == 0 && la[n_log-2] == 12'h102 && ld[n_log-2] == 0 &&
        lk[n_log-1] == 2 && la[n_log-1] == 2, "R11 ending after eq fail", n_log, 0);

    // R8 R9: aligned but lane bits incomplete
    clear_cfg(); cfg_eq_at = 0; cfg_eq_nib = 16'h3333; cfg_align = 1'b1;
    run(4, 1'b0, 8'h12);
    chk(eq_n == 7 && !res_eq, "R8 R9 lane eq bits needed", eq_n, 7);

    // R8: inactive lanes ignored in equalization
    clear_cfg(); cfg_eq_at = 0; cfg_eq_nib = 16'h0007; cfg_align = 1'b1;
    run(1, 1'b0, 8'h12);
    chk(eq_n == 1 && res_eq, "R8 inactive lanes ignored", eq_n, 1);

    // R10: read failures
    clear_cfg(); cfg_cr_at = 0; cfg_cr_fail_at = 1;
    run(2, 1'b0, 8'h12);
    chk(cr_n == 1 && !res_cr && res_eq, "R10 cr read failure", cr_n, 1);
    clear_cfg(); cfg_eq_at = 0; cfg_eq_fail_at = 1;
    run(2, 1'b0, 8'h12);
    chk(eq_n == 1 && res_cr && !res_eq, "R10 eq read failure", eq_n, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 190000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule